// File: doc/BRIEF.md
# Operand Specifier Fetch Unit

This unit resolves one operand of a two-operand 16-bit machine with eight general registers. Register 6 serves as the stack pointer and register 7 as the program counter, and every addressing mode can name either of them like any other register. A caller presents a 6-bit specifier, made of a 3-bit mode and a 3-bit register number, together with a byte/word size flag and a flag that marks the operand as a destination. It then pulses start. The unit reads and updates the external register file for the stepping modes. It issues the word reads needed to form the effective address and, for source operands, reads the operand itself.

When it finishes, the unit pulses done for one cycle with the result. The result is either a register location, flagged so that write-back goes to the register file, or a memory address with the fetched value. Immediate and absolute operands need no modes of their own. The autoincrement mode on the program counter reads the inline word, and the deferred autoincrement mode on the program counter uses the inline word as an address.

The register file is outside the unit. It has one combinational read port and one write port that share the register number output. Memory is a single-port word memory with a request/ready handshake. Addresses are byte addresses and memory requests always carry an even address.

Top module: `opf_top`

## Requirements
- R1: Mode 0 (register) issues no memory read and finishes with is_reg_o=1, addr_o equal to the register number, and data_o equal to the register value (byte size: low 8 bits, zero-extended).
- R2: Mode 1 (register deferred) reads the operand at the address held in the register and leaves the register unchanged.
- R3: Mode 2 (autoincrement) uses the register value as the operand address, then adds the step to the register.
- R4: Mode 4 (autodecrement) subtracts the step from the register first and uses the new value as the operand address.
- R5: The step is 1 only for byte operands in modes 2 or 4 on registers 0 to 5. It is 2 for word operands, for registers 6 and 7, and for the deferred modes 3 and 5.
- R6: Modes 3 and 5 step the register as modes 2 and 4 do, but the word read at the register-derived address is the operand address.
- R7: Mode 6 (index) reads the word at the program counter, adds 2 to the program counter, and uses that word plus the register as the address. For register 7 the advanced program counter is the value added.
- R8: Mode 7 (index deferred) forms the address as in mode 6, reads a word there, and uses that word as the operand address.
- R9: Mode 2 on register 7 yields the inline word as an immediate operand, and mode 3 on register 7 yields an absolute address. Both advance the program counter by 2 for either size.
- R10: Byte operands are taken from the high half of the word when address bit 0 is 1 and from the low half when it is 0, zero-extended. mem_addr_o bit 0 is always 0.
- R11: With dest_i=1 the final operand read is skipped and addr_o gives the location. The read counts per mode are 0,1,1,2,1,2,2,3 for a source and one fewer for a destination in modes 1 to 7.
- R12: mem_req_o stays high with mem_addr_o unchanged until mem_ready_i is seen; results are unaffected by wait states.
- R13: done_o is a one-cycle pulse, busy_o is high from the cycle after an accepted start until done, and start_i is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin resolving a specifier (taken when idle) |
| mode_i | input | 3 | Addressing mode |
| reg_i | input | 3 | Register number |
| byte_i | input | 1 | 1 for byte operand, 0 for word |
| dest_i | input | 1 | 1 for destination: skip the operand read |
| busy_o | output | 1 | Unit is working on a specifier |
| done_o | output | 1 | One-cycle result strobe |
| is_reg_o | output | 1 | Result is a register location |
| addr_o | output | 16 | Operand byte address, or register number when is_reg_o |
| data_o | output | 16 | Operand value (zero-extended for bytes) |
| rf_addr_o | output | 3 | Register number for read and write |
| rf_rdata_i | input | 16 | Register read data (combinational) |
| rf_we_o | output | 1 | Register write enable |
| rf_wdata_o | output | 16 | Register write data |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory byte address (even) |
| mem_ready_i | input | 1 | Memory accepts the request; data valid |
| mem_rdata_i | input | 16 | Memory read word |

## Verification
The hardest situations involve the program counter. It is read as an address and rewritten while the memory side stalls, and index mode on register 7 must then add the advanced value. The bench memory model takes a wait-state count, so the inline fetch can be held for several cycles while the program counter value on the register port has to stay steady. The bench also pulses start in the middle of a stalled operation to show that a second specifier leaves the running one untouched.

// File: rtl/opf_pkg.sv
package opf_pkg;
  typedef enum logic [2:0] {
    M_REG, M_REG_DEF, M_INC, M_INC_DEF, M_DEC, M_DEC_DEF, M_IDX, M_IDX_DEF
  } amode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_REG, S_INL, S_IDX, S_PTR, S_OPD
  } state_e;
endpackage

// File: rtl/opf_adj.sv
module opf_adj
  import opf_pkg::*;
#(
  parameter int W    = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic [W-1:0]  val_i,
  input  amode_e        mode_i,
  input  logic          byte_i,
  input  logic [RW-1:0] reg_i,
  output logic [W-1:0]  inc_o,
  output logic [W-1:0]  dec_o
);
  localparam logic [RW-1:0] SP_IDX = RW'(NREG - 2);
  logic [W-1:0] step;

  // unit step only for byte data through a plain register
  always_comb begin
    step = W'(2);
    if (byte_i && (reg_i < SP_IDX) && (mode_i == M_INC || mode_i == M_DEC))
      step = W'(1);
  end

  assign inc_o = val_i + step;
  assign dec_o = val_i - step;
endmodule

// File: rtl/opf_lane.sv
module opf_lane #(
  parameter int W = 16,
  localparam int H = W / 2
) (
  input  logic [W-1:0] word_i,
  input  logic         sel_hi_i,
  input  logic         byte_i,
  output logic [W-1:0] data_o
);
  assign data_o = byte_i ? {{H{1'b0}}, (sel_hi_i ? word_i[W-1:H] : word_i[H-1:0])}
                         : word_i;
endmodule

// File: rtl/opf_top.sv
module opf_top
  import opf_pkg::*;
#(
  parameter int W    = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    mode_i,
  input  logic [RW-1:0] reg_i,
  input  logic          byte_i,
  input  logic          dest_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          is_reg_o,
  output logic [W-1:0]  addr_o,
  output logic [W-1:0]  data_o,
  output logic [RW-1:0] rf_addr_o,
  input  logic [W-1:0]  rf_rdata_i,
  output logic          rf_we_o,
  output logic [W-1:0]  rf_wdata_o,
  output logic          mem_req_o,
  output logic [W-1:0]  mem_addr_o,
  input  logic          mem_ready_i,
  input  logic [W-1:0]  mem_rdata_i
);
  localparam logic [RW-1:0] PC_IDX = RW'(NREG - 1);

  state_e        state_q;
  amode_e        mode_q;
  logic [RW-1:0] reg_q;
  logic          byte_q, dest_q;
  logic [W-1:0]  ptr_q, ea_q, ea_n;
  logic          ea_ok, acc;
  logic          done_q, is_reg_q;
  logic [W-1:0]  addr_q, data_q;
  logic [W-1:0]  inc_val, dec_val, idx_sum, mem_lane, reg_lane, raw_addr;
  logic          step_mode;

  opf_adj #(.W(W), .NREG(NREG)) u_adj (
    .val_i (rf_rdata_i),
    .mode_i(mode_q),
    .byte_i(byte_q),
    .reg_i (reg_q),
    .inc_o (inc_val),
    .dec_o (dec_val)
  );

  opf_lane #(.W(W)) u_mem_lane (
    .word_i  (mem_rdata_i),
    .sel_hi_i(ea_q[0]),
    .byte_i  (byte_q),
    .data_o  (mem_lane)
  );

  opf_lane #(.W(W)) u_reg_lane (
    .word_i  (rf_rdata_i),
    .sel_hi_i(1'b0),
    .byte_i  (byte_q),
    .data_o  (reg_lane)
  );

  assign idx_sum   = rf_rdata_i + ptr_q;
  assign step_mode = mode_q inside {M_INC, M_INC_DEF, M_DEC, M_DEC_DEF};

  // register and memory side
  assign rf_addr_o = (state_q == S_INL) ? PC_IDX : reg_q;
  assign mem_req_o = state_q inside {S_INL, S_PTR, S_OPD};
  assign acc       = mem_req_o && mem_ready_i;

  always_comb begin
    unique case (state_q)
      S_INL:   raw_addr = rf_rdata_i;
      S_PTR:   raw_addr = ptr_q;
      default: raw_addr = ea_q;
    endcase
  end
  assign mem_addr_o = {raw_addr[W-1:1], 1'b0};

  assign rf_we_o    = ((state_q == S_REG) && step_mode) || ((state_q == S_INL) && acc);
  assign rf_wdata_o = (state_q == S_INL) ? rf_rdata_i + W'(2)
                    : (mode_q inside {M_INC, M_INC_DEF}) ? inc_val : dec_val;

  // effective address formed this cycle
  always_comb begin
    ea_n  = ea_q;
    ea_ok = 1'b0;
    unique case (state_q)
      S_REG: begin
        if (mode_q == M_REG_DEF || mode_q == M_INC) begin
          ea_n = rf_rdata_i; ea_ok = 1'b1;
        end else if (mode_q == M_DEC) begin
          ea_n = dec_val; ea_ok = 1'b1;
        end
      end
      S_IDX: if (mode_q == M_IDX) begin ea_n = idx_sum; ea_ok = 1'b1; end
      S_PTR: if (acc) begin ea_n = mem_rdata_i; ea_ok = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      mode_q   <= M_REG;
      reg_q    <= '0;
      byte_q   <= 1'b0;
      dest_q   <= 1'b0;
      ptr_q    <= '0;
      ea_q     <= '0;
      done_q   <= 1'b0;
      is_reg_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (ea_ok) begin
        ea_q <= ea_n;
        if (dest_q) begin
          done_q   <= 1'b1;
          is_reg_q <= 1'b0;
          addr_q   <= ea_n;
          data_q   <= '0;
          state_q  <= S_IDLE;
        end else begin
          state_q <= S_OPD;
        end
      end else begin
        unique case (state_q)
          S_IDLE: if (start_i) begin
            mode_q  <= amode_e'(mode_i);
            reg_q   <= reg_i;
            byte_q  <= byte_i;
            dest_q  <= dest_i;
            state_q <= S_REG;
          end
          S_REG: begin
            unique case (mode_q)
              M_REG: begin
                done_q   <= 1'b1;
                is_reg_q <= 1'b1;
                addr_q   <= W'(reg_q);
                data_q   <= reg_lane;
                state_q  <= S_IDLE;
              end
              M_INC_DEF: begin ptr_q <= rf_rdata_i; state_q <= S_PTR; end
              M_DEC_DEF: begin ptr_q <= dec_val;    state_q <= S_PTR; end
              M_IDX, M_IDX_DEF: state_q <= S_INL;
              default: state_q <= S_IDLE;
            endcase
          end
          S_INL: if (acc) begin ptr_q <= mem_rdata_i; state_q <= S_IDX; end
          S_IDX: begin ptr_q <= idx_sum; state_q <= S_PTR; end
          S_OPD: if (acc) begin
            done_q   <= 1'b1;
            is_reg_q <= 1'b0;
            addr_q   <= ea_q;
            data_q   <= mem_lane;
            state_q  <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = done_q;
  assign is_reg_o = is_reg_q;
  assign addr_o   = addr_q;
  assign data_o   = data_q;

  // R12: request held steady across wait states
  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));

  // R13: result strobe lasts one cycle
  p_done_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R13: accepted start makes the unit busy
  p_start_busy_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  // R5: stack pointer and program counter keep their parity
  p_sp_pc_even_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o && (rf_addr_o >= RW'(NREG - 2)) |-> rf_wdata_o[0] == rf_rdata_i[0]);

  // R1: register operands never touch memory
  p_reg_nomem_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && is_reg_o |-> !$past(mem_req_o));
endmodule

// File: tb/opf_top_tb_top.sv
module opf_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0, regn = '0;
  logic        bsz = 1'b0, dst = 1'b0;
  logic        busy, done, is_reg;
  logic [15:0] addr, data;
  logic [2:0]  rf_addr;
  logic [15:0] rf_rdata, rf_wdata;
  logic        rf_we;
  logic        mem_req, mem_ready;
  logic [15:0] mem_addr, mem_rdata;

  logic [15:0] rf  [8];
  logic [15:0] mem [256];
  logic        set_we = 1'b0;
  logic [2:0]  set_idx = '0;
  logic [15:0] set_val = '0;
  int          wait_n = 0;
  int          wcnt = 0;
  int          rd_cnt = 0;
  int          odd_seen = 0;
  int          n_chk = 0, n_bad = 0;
  logic [15:0] r_addr, r_data;
  logic        r_isreg;
  int          r_reads;

  always #10 clk = ~clk;

  opf_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .reg_i(regn),
    .byte_i(bsz), .dest_i(dst), .busy_o(busy), .done_o(done), .is_reg_o(is_reg),
    .addr_o(addr), .data_o(data), .rf_addr_o(rf_addr), .rf_rdata_i(rf_rdata),
    .rf_we_o(rf_we), .rf_wdata_o(rf_wdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
  );

  assign rf_rdata  = rf[rf_addr];
  assign mem_rdata = mem[mem_addr[8:1]];
  assign mem_ready = mem_req && (wcnt >= wait_n);

  always @(posedge clk) begin
    if (set_we) rf[set_idx] <= set_val;
    else if (rf_we) rf[rf_addr] <= rf_wdata;
    if (mem_req && !mem_ready) wcnt <= wcnt + 1; else wcnt <= 0;
    if (mem_req && mem_ready) rd_cnt <= rd_cnt + 1;
    if (mem_req && mem_addr[0]) odd_seen <= odd_seen + 1;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_reg(input logic [2:0] i, input logic [15:0] v);
    @(negedge clk);
    set_we = 1'b1; set_idx = i; set_val = v;
    @(negedge clk);
    set_we = 1'b0;
  endtask

  task automatic wmem(input logic [15:0] a, input logic [15:0] v);
    mem[a[8:1]] = v;
  endtask

  task automatic run_op(input logic [2:0] m, input logic [2:0] r, input logic b, input logic d);
    int base, tmo;
    @(negedge clk);
    base = rd_cnt;
    mode = m; regn = r; bsz = b; dst = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tmo = 0;
    while (!done && tmo < 100) begin @(negedge clk); tmo++; end
    if (tmo >= 100) begin n_chk++; n_bad++; $display("FAIL R13: no done, actual 0 expected 1"); end
    r_addr = addr; r_data = data; r_isreg = is_reg; r_reads = rd_cnt - base;
    @(negedge clk);
    chk("R13 pulse", 16'(done), 16'd0);
  endtask

  task automatic t_reset;
    chk("R13 reset busy", 16'(busy), 16'd0);
    chk("R13 reset done", 16'(done), 16'd0);
    chk("R12 reset req", 16'(mem_req), 16'd0);
  endtask

  task automatic t_register;  // R1
    set_reg(3, 16'h1234);
    run_op(0, 3, 0, 0);
    chk("R1 isreg", 16'(r_isreg), 16'd1);
    chk("R1 addr", r_addr, 16'd3);
    chk("R1 data", r_data, 16'h1234);
    chk("R1 reads", 16'(r_reads), 16'd0);
    run_op(0, 3, 1, 0);
    chk("R1 byte data", r_data, 16'h0034);
    run_op(0, 3, 0, 1);
    chk("R1 dest isreg", 16'(r_isreg), 16'd1);
  endtask

  task automatic t_deferred;  // R2 R10
    set_reg(1, 16'h0040);
    wmem(16'h0040, 16'hBEEF);
    run_op(1, 1, 0, 0);
    chk("R2 data", r_data, 16'hBEEF);
    chk("R2 reg kept", rf[1], 16'h0040);
    chk("R2 reads", 16'(r_reads), 16'd1);
    set_reg(1, 16'h0041);
    run_op(1, 1, 1, 0);
    chk("R10 high lane", r_data, 16'h00BE);
    chk("R10 addr", r_addr, 16'h0041);
  endtask

  task automatic t_autoinc;  // R3 R5 R10
    set_reg(2, 16'h0060);
    wmem(16'h0060, 16'hA55A);
    run_op(2, 2, 0, 0);
    chk("R3 data", r_data, 16'hA55A);
    chk("R3 addr", r_addr, 16'h0060);
    chk("R3 reg", rf[2], 16'h0062);
    set_reg(2, 16'h0060);
    run_op(2, 2, 1, 0);
    chk("R10 low lane", r_data, 16'h005A);
    chk("R5 byte step", rf[2], 16'h0061);
    run_op(2, 2, 1, 0);
    chk("R10 odd lane", r_data, 16'h00A5);
    chk("R5 byte step2", rf[2], 16'h0062);
  endtask

  task automatic t_autodec;  // R4 R5
    set_reg(4, 16'h0080);
    wmem(16'h007E, 16'h2211);
    run_op(4, 4, 0, 0);
    chk("R4 addr", r_addr, 16'h007E);
    chk("R4 data", r_data, 16'h2211);
    chk("R4 reg", rf[4], 16'h007E);
    set_reg(4, 16'h0080);
    run_op(4, 4, 1, 0);
    chk("R4 byte addr", r_addr, 16'h007F);
    chk("R4 byte data", r_data, 16'h0022);
    set_reg(6, 16'h01F0);
    run_op(4, 6, 1, 1);
    chk("R5 sp step", rf[6], 16'h01EE);
    chk("R11 sp addr", r_addr, 16'h01EE);
  endtask

  task automatic t_ptr_modes;  // R6 R5
    set_reg(5, 16'h00A0);
    wmem(16'h00A0, 16'h00C0);
    wmem(16'h00C0, 16'h3344);
    run_op(3, 5, 1, 0);
    chk("R6 inc def data", r_data, 16'h0044);
    chk("R5 deferred step", rf[5], 16'h00A2);
    chk("R6 reads", 16'(r_reads), 16'd2);
    run_op(5, 5, 0, 0);
    chk("R6 dec def data", r_data, 16'h3344);
    chk("R6 dec def reg", rf[5], 16'h00A0);
  endtask

  task automatic t_pc_modes;  // R9
    set_reg(7, 16'h0100);
    wmem(16'h0100, 16'h5A5A);
    wmem(16'h0102, 16'h0077);
    wmem(16'h0104, 16'h0140);
    wmem(16'h0140, 16'h4444);
    run_op(2, 7, 0, 0);
    chk("R9 imm", r_data, 16'h5A5A);
    chk("R9 imm pc", rf[7], 16'h0102);
    run_op(2, 7, 1, 0);
    chk("R9 byte imm", r_data, 16'h0077);
    chk("R9 byte pc", rf[7], 16'h0104);
    run_op(3, 7, 0, 0);
    chk("R9 abs", r_data, 16'h4444);
    chk("R9 abs pc", rf[7], 16'h0106);
  endtask

  task automatic t_index;  // R7 R8
    set_reg(1, 16'h0020);
    set_reg(7, 16'h0106);
    wmem(16'h0106, 16'h0010);
    wmem(16'h0030, 16'h6666);
    run_op(6, 1, 0, 0);
    chk("R7 addr", r_addr, 16'h0030);
    chk("R7 data", r_data, 16'h6666);
    chk("R7 pc", rf[7], 16'h0108);
    chk("R7 reads", 16'(r_reads), 16'd2);
    wmem(16'h0108, 16'h0020);
    wmem(16'h012A, 16'h7777);
    run_op(6, 7, 0, 0);
    chk("R7 pc relative", r_addr, 16'h012A);
    chk("R7 pc rel data", r_data, 16'h7777);
    wmem(16'h010A, 16'h0002);
    wmem(16'h0022, 16'h0150);
    wmem(16'h0150, 16'h8888);
    run_op(7, 1, 0, 0);
    chk("R8 addr", r_addr, 16'h0150);
    chk("R8 data", r_data, 16'h8888);
    chk("R8 reads", 16'(r_reads), 16'd3);
    chk("R8 reg kept", rf[1], 16'h0020);
  endtask

  task automatic t_dest;  // R11
    set_reg(1, 16'h0020);
    run_op(1, 1, 0, 1);
    chk("R11 m1 addr", r_addr, 16'h0020);
    chk("R11 m1 reads", 16'(r_reads), 16'd0);
    chk("R11 m1 isreg", 16'(r_isreg), 16'd0);
    set_reg(7, 16'h010C);
    wmem(16'h010C, 16'h0160);
    run_op(3, 7, 0, 1);
    chk("R11 abs addr", r_addr, 16'h0160);
    chk("R11 abs reads", 16'(r_reads), 16'd1);
    chk("R11 abs pc", rf[7], 16'h010E);
  endtask

  task automatic t_wait;  // R12
    wait_n = 3;
    set_reg(1, 16'h0020);
    set_reg(7, 16'h010A);
    run_op(7, 1, 0, 0);
    chk("R12 addr", r_addr, 16'h0150);
    chk("R12 data", r_data, 16'h8888);
    chk("R12 pc", rf[7], 16'h010C);
    chk("R12 reads", 16'(r_reads), 16'd3);
    chk("R10 even addr", 16'(odd_seen), 16'd0);
    wait_n = 0;
  endtask

  task automatic t_busy_ignore;  // R13
    int base, tmo, ndone;
    wait_n = 2;
    set_reg(2, 16'h0060);
    set_reg(3, 16'h1234);
    @(negedge clk);
    base = rd_cnt;
    mode = 2; regn = 2; bsz = 0; dst = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R13 busy", 16'(busy), 16'd1);
    @(negedge clk);
    mode = 0; regn = 3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tmo = 0;
    while (!done && tmo < 100) begin @(negedge clk); tmo++; end
    chk("R13 ignored start data", data, 16'hA55A);
    chk("R13 ignored start isreg", 16'(is_reg), 16'd0);
    ndone = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (done) ndone++; end
    chk("R13 single done", 16'(ndone), 16'd0);
    chk("R13 reads", 16'(rd_cnt - base), 16'd1);
    chk("R13 reg once", rf[2], 16'h0062);
    wait_n = 0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_register;
    t_deferred;
    t_autoinc;
    t_autodec;
    t_ptr_modes;
    t_pc_modes;
    t_index;
    t_dest;
    t_wait;
    t_busy_ignore;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R13: watchdog expired, actual hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule